// File: doc/BRIEF.md
# Serial Port Modem Control and Status Unit

This unit holds the modem control byte and the modem status byte of a 16550-style serial port. The host writes the control byte to drive four active-low handshake outputs (request-to-send, terminal-ready and two auxiliary lines). It reads the status byte to see the present level of the four active-low handshake inputs (clear-to-send, set-ready, ring, carrier) and a set of change flags. The change flags stay set until the status byte is read. The ring flag records only the end of a ring pulse.

The external inputs pass through a parameterised flop synchroniser before change detection. A loopback bit in the control byte routes each handshake output back to a fixed status input and holds the external output pins inactive. Whenever any status line changes, the unit raises a one-cycle notification that carries the updated status byte as byte 0 and the line-status byte supplied by the data path as byte 1.

Top module: `mdm_ctl_stat`

## Requirements
- R1: Status byte bits 7, 6, 5 and 4 show carrier, ring, set-ready and clear-to-send as 1 when the corresponding active-low pin is low.
- R2: Status bits 3 (carrier), 1 (set-ready) and 0 (clear-to-send) become 1 when that line has changed one or more times since the last status read, and stay 1 until that read.
- R3: Status bit 2 becomes 1 only when the ring pin goes from low to high. A high-to-low ring transition leaves it at 0.
- R4: A status read (read strobe with address 1) returns the current byte and clears bits 3..0 at that clock edge. A change taken in on the same edge still sets its bit.
- R5: Control bit 0 drives the terminal-ready pin low, bit 1 the request-to-send pin, bit 2 auxiliary pin 1 and bit 3 auxiliary pin 2, each when the bit is 1. After reset all four pins are high and both bytes read 0.
- R6: Address 0 selects the control byte and address 1 selects the status byte. Control bits 7..5 always read 0, whatever was written.
- R7: With control bit 4 set, request-to-send feeds clear-to-send, terminal-ready feeds set-ready, auxiliary 1 feeds ring and auxiliary 2 feeds carrier. The external input pins then have no effect on the status byte.
- R8: While control bit 4 is set, loop_o is 1 and all four external output pins are held high.
- R9: On every status-line change, pkt_vld_o is high for one cycle, with pkt_msr_o equal to the updated status byte and pkt_lsr_o equal to lsr_i. No notification occurs without a change.
- R10: An external pin change appears in the status byte SYNC_STAGES+1 clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 = control byte, 1 = status byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| lsr_i | input | 8 | Line-status byte from the data path |
| cts_ni | input | 1 | Clear-to-send pin, active low |
| dsr_ni | input | 1 | Set-ready pin, active low |
| ri_ni | input | 1 | Ring pin, active low |
| dcd_ni | input | 1 | Carrier pin, active low |
| rts_no | output | 1 | Request-to-send pin, active low |
| dtr_no | output | 1 | Terminal-ready pin, active low |
| out1_no | output | 1 | Auxiliary output 1, active low |
| out2_no | output | 1 | Auxiliary output 2, active low |
| loop_o | output | 1 | Loopback enable for the data path |
| pkt_vld_o | output | 1 | Notification valid, one cycle |
| pkt_msr_o | output | 8 | Notification byte 0 (status byte) |
| pkt_lsr_o | output | 8 | Notification byte 1 (line status) |

## Verification
The bench builds the unit with SYNC_STAGES = 3 rather than the default 2. This shows that the latency follows the parameter and is not fixed at one value. The extra stage also widens the window for the case in R4: a read strobe placed on exactly the edge where a change lands in the status byte. Every expected notification goes into a queue before the pin or register change that causes it. A stray or missing notification therefore shows up both as a failed compare and in the final queue check.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  // control byte bit positions
  localparam int unsigned MCR_DTR  = 0;
  localparam int unsigned MCR_RTS  = 1;
  localparam int unsigned MCR_OUT1 = 2;
  localparam int unsigned MCR_OUT2 = 3;
  localparam int unsigned MCR_LOOP = 4;
  localparam int unsigned MCR_W    = 5;
  // line vector order, MSB first: carrier, ring, set-ready, clear-to-send
  localparam int unsigned LN_DCD = 3;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_W   = 4;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;

  // pins idle high, so reset to ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '1;
    end else begin
      st_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) st_q[k] <= st_q[k-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
  import mdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MCR_W-1:0]  wdata_i,
  output logic [MCR_W-1:0]  mcr_o,
  output logic              rts_no,
  output logic              dtr_no,
  output logic              out1_no,
  output logic              out2_no,
  output logic              loop_o
);
  logic [MCR_W-1:0] mcr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mcr_q <= '0;
    else if (wr_i) mcr_q <= wdata_i;
  end

  assign mcr_o  = mcr_q;
  assign loop_o = mcr_q[MCR_LOOP];
  // loopback parks the external pins inactive
  assign rts_no  = loop_o | ~mcr_q[MCR_RTS];
  assign dtr_no  = loop_o | ~mcr_q[MCR_DTR];
  assign out1_no = loop_o | ~mcr_q[MCR_OUT1];
  assign out2_no = loop_o | ~mcr_q[MCR_OUT2];

  // R8
  loop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_o |-> (rts_no && dtr_no && out1_no && out2_no));

  // R5
  wr_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mcr_o == $past(wdata_i)));
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LN_W-1:0]   ext_i,   // synchronised, active high
  input  logic [MCR_W-1:0]  mcr_i,
  input  logic              clr_i,
  output logic [7:0]        msr_o,
  output logic              pkt_vld_o
);
  logic [LN_W-1:0] lb, eff, chg, set, line_q, dlt_q;
  logic            pkt_q;

  assign lb = {mcr_i[MCR_OUT2], mcr_i[MCR_OUT1], mcr_i[MCR_DTR], mcr_i[MCR_RTS]};
  assign eff = mcr_i[MCR_LOOP] ? lb : ext_i;
  assign chg = eff ^ line_q;

  always_comb begin
    set         = chg;
    // ring flag only on pin rising, i.e. level going inactive
    set[LN_RI]  = line_q[LN_RI] & ~eff[LN_RI];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      dlt_q  <= '0;
      pkt_q  <= 1'b0;
    end else begin
      line_q <= eff;
      dlt_q  <= (clr_i ? '0 : dlt_q) | set;
      pkt_q  <= |chg;
    end
  end

  assign msr_o     = {line_q, dlt_q};
  assign pkt_vld_o = pkt_q;

  // R2
  dlt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((dlt_q & $past(dlt_q)) == $past(dlt_q)));

  // R3
  teri_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dlt_q[LN_RI]) |-> ($past(line_q[LN_RI]) && !line_q[LN_RI]));

  // R4
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && chg == '0) |=> (dlt_q == '0));

  // R9
  pkt_on_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q != $past(line_q)) |-> pkt_vld_o);

  // R7
  loop_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mcr_i[MCR_LOOP]) |-> (line_q == {$past(mcr_i[MCR_OUT2]), $past(mcr_i[MCR_OUT1]),
                                          $past(mcr_i[MCR_DTR]), $past(mcr_i[MCR_RTS])}));
endmodule

// File: rtl/mdm_ctl_stat.sv
module mdm_ctl_stat
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic       addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [7:0] lsr_i,
  input  logic       cts_ni,
  input  logic       dsr_ni,
  input  logic       ri_ni,
  input  logic       dcd_ni,
  output logic       rts_no,
  output logic       dtr_no,
  output logic       out1_no,
  output logic       out2_no,
  output logic       loop_o,
  output logic       pkt_vld_o,
  output logic [7:0] pkt_msr_o,
  output logic [7:0] pkt_lsr_o
);
  localparam int unsigned RSVD_W = 8 - MCR_W;

  logic [LN_W-1:0]  pin_sync;
  logic [MCR_W-1:0] mcr;
  logic [7:0]       msr;
  logic             unused_rsvd;

  assign unused_rsvd = &{1'b0, wdata_i[7:MCR_W]};

  mdm_sync #(.WIDTH(LN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({dcd_ni, ri_ni, dsr_ni, cts_ni}),
    .q_o    (pin_sync)
  );

  mdm_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && !addr_i),
    .wdata_i (wdata_i[MCR_W-1:0]),
    .mcr_o   (mcr),
    .rts_no  (rts_no),
    .dtr_no  (dtr_no),
    .out1_no (out1_no),
    .out2_no (out2_no),
    .loop_o  (loop_o)
  );

  mdm_status u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_i     (~pin_sync),
    .mcr_i     (mcr),
    .clr_i     (rd_en_i && addr_i),
    .msr_o     (msr),
    .pkt_vld_o (pkt_vld_o)
  );

  assign rdata_o   = addr_i ? msr : {{RSVD_W{1'b0}}, mcr};
  assign pkt_msr_o = msr;
  assign pkt_lsr_o = lsr_i;

  // R6
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> (rdata_o[7:MCR_W] == '0));
endmodule

// File: tb/mdm_ctl_stat_test.sv
`timescale 1ns/1ps
module mdm_ctl_stat_test;
  localparam int unsigned STG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, addr = 0;
  logic [7:0] wdata = 0, lsr = 8'h60;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic [7:0] rdata, pmsr, plsr;
  logic rts_n, dtr_n, o1_n, o2_n, loop, pvld;

  int checks = 0, errs = 0;
  logic [15:0] sb_q[$];

  always #2.5 clk = ~clk;

  mdm_ctl_stat #(.SYNC_STAGES(STG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .lsr_i(lsr),
    .cts_ni(cts_n), .dsr_ni(dsr_n), .ri_ni(ri_n), .dcd_ni(dcd_n),
    .rts_no(rts_n), .dtr_no(dtr_n), .out1_no(o1_n), .out2_no(o2_n), .loop_o(loop),
    .pkt_vld_o(pvld), .pkt_msr_o(pmsr), .pkt_lsr_o(plsr)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_pkt(logic [7:0] m);
    sb_q.push_back({m, lsr});
  endtask

  task automatic wr_mcr(logic [7:0] v);
    addr = 0; wdata = v; wr_en = 1;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic rd_reg(logic a, string req, logic [7:0] exp);
    addr = a; rd_en = 1;
    #1 check(req, {8'h0, rdata}, {8'h0, exp});
    cyc(1);
    rd_en = 0;
  endtask

  task automatic pins(string req, logic [3:0] exp);
    check(req, {12'h0, rts_n, dtr_n, o1_n, o2_n}, {12'h0, exp});
  endtask

  // monitor: every notification must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && pvld) begin
      if (sb_q.size() == 0) check("R9 unexpected pkt", {pmsr, plsr}, 16'hxxxx);
      else check("R9 pkt", {pmsr, plsr}, sb_q.pop_front());
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R10 watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R5 R6 reset state
    rd_reg(0, "R5 reset mcr", 8'h00);
    rd_reg(1, "R5 reset msr", 8'h00);
    pins("R5 reset pins", 4'hF);
    check("R8 reset loop", {15'h0, loop}, 16'h0);

    // R5 handshake outputs
    wr_mcr(8'h03);
    pins("R5 dtr rts", 4'b0011);
    // R6 reserved bits
    wr_mcr(8'hEC);
    pins("R5 aux", 4'b1100);
    rd_reg(0, "R6 rsvd zero", 8'h0C);
    wr_mcr(8'h00);
    pins("R5 cleared", 4'hF);

    // R1 R2 R10 clear-to-send low
    push_pkt(8'h11);
    cts_n = 0;
    cyc(STG);
    rd_reg(1, "R10 not before latency", 8'h00);
    cyc(1);
    rd_reg(1, "R1 R2 cts", 8'h11);
    rd_reg(1, "R4 cleared", 8'h10);

    // R2 sticky across two changes
    push_pkt(8'h32);
    dsr_n = 0;
    cyc(STG + 2);
    push_pkt(8'h12);
    dsr_n = 1;
    cyc(STG + 2);
    rd_reg(1, "R2 sticky dsr", 8'h12);

    // R3 ring: leading edge sets nothing, trailing edge sets bit 2
    push_pkt(8'h50);
    ri_n = 0;
    cyc(STG + 2);
    rd_reg(1, "R3 ring leading", 8'h50);
    push_pkt(8'h14);
    ri_n = 1;
    cyc(STG + 2);
    rd_reg(1, "R3 ring trailing", 8'h14);
    rd_reg(1, "R4 teri cleared", 8'h10);

    // R1 R2 carrier with a different line status byte
    lsr = 8'h1E;
    push_pkt(8'h98);
    dcd_n = 0;
    cyc(STG + 2);
    rd_reg(1, "R1 dcd", 8'h98);
    push_pkt(8'h18);
    dcd_n = 1;
    cyc(STG + 2);
    rd_reg(1, "R2 dcd back", 8'h18);
    rd_reg(1, "R4 dcd cleared", 8'h10);

    // R4 read on the same edge as a change
    push_pkt(8'h01);
    cts_n = 1;
    cyc(STG);
    rd_reg(1, "R4 same edge read", 8'h10);
    rd_reg(1, "R4 same edge kept", 8'h01);
    rd_reg(1, "R4 then clear", 8'h00);

    // R7 R8 loopback
    wr_mcr(8'h10);
    check("R8 loop", {15'h0, loop}, 16'h1);
    pins("R8 loop pins", 4'hF);
    cts_n = 0;
    cyc(STG + 2);
    rd_reg(1, "R7 ext ignored", 8'h00);
    push_pkt(8'hFB);
    wr_mcr(8'h1F);
    cyc(2);
    pins("R8 pins idle", 4'hF);
    rd_reg(1, "R7 route on", 8'hFB);
    rd_reg(1, "R7 route cleared", 8'hF0);
    push_pkt(8'h0F);
    wr_mcr(8'h10);
    cyc(2);
    rd_reg(1, "R7 R3 route off", 8'h0F);
    push_pkt(8'h11);
    wr_mcr(8'h00);
    cyc(2);
    pins("R8 loop exit", 4'hF);
    rd_reg(1, "R7 ext back", 8'h11);

    cyc(STG + 3);
    check("R9 all pkts seen", 16'(sb_q.size()), 16'h0);
    finish_run();
  end
endmodule